// File: doc/BRIEF.md
# Fetch Next-Address Predictor

This block owns the fetch address of a five-stage in-order pipeline and decides, every cycle, which address is fetched next. The decoder in fetch presents the class of the instruction at the current fetch address, its length in bytes and its embedded constant target. From these the block forms the fall-through address and a predicted next address. It then commits one of three sources into the fetch address register. The first is a correction from execute when a conditional jump turns out mispredicted. The second is a return address delivered by writeback. The third is its own prediction.

The instruction side is a valid/ready stream. The decoder raises `in_valid` with a stable instruction description, and the instruction counts as consumed on any edge where `in_valid` and `in_ready` are both high. Once a return has been consumed, the block drops `in_ready` and holds the fetch address. It keeps this back-pressure until writeback supplies the return address or execute squashes the path. Meanwhile the decoder must keep its word pending. Correction inputs are plain single-cycle pulses and need no handshake.

For each consumed instruction the block also reports the fall-through address and whether later stages need it. Conditional jumps need it for recovery, and calls need it as the return address to push. It also reports the taken/not-taken guess for the instruction.

Top module: `npc_predictor`

## Requirements
- R1: After reset `fetch_pc` equals parameter `RESET_PC` (default 0), `in_ready` is 1, and `fetch_pc` holds while no instruction is consumed and no correction arrives.
- R2: `out_valp` always equals `fetch_pc + in_len`, where `in_len` is one of 1, 2, 5 or 6.
- R3: A consumed instruction of class jump (`in_class`=2) or call (`in_class`=3) loads `in_valc` into `fetch_pc` on that edge.
- R4: A consumed instruction of class other (`in_class`=0, or 5 to 7) loads the fall-through address into `fetch_pc`.
- R5: A consumed conditional jump (`in_class`=1) follows parameter `POLICY`: 0 always loads `in_valc`; 1 always loads the fall-through; 2 (default) loads `in_valc` only when `in_valc` is below the fall-through address as unsigned numbers. `out_pred_taken` reports the same guess, is 1 for jump and call, and is 0 for other classes.
- R6: A consumed return (`in_class`=4) leaves `fetch_pc` unchanged and drops `in_ready` from the next cycle. `fetch_pc` then holds until a `wb_ret_valid` pulse loads `wb_ret_pc` and raises `in_ready` again.
- R7: An `ex_mispredict` pulse loads `ex_alt_pc` into `fetch_pc` on that edge, whatever else is asserted, and ends any wait for a return.
- R8: When no mispredict is present, a `wb_ret_valid` pulse loads `wb_ret_pc` even if an instruction is consumed on the same edge.
- R9: `out_valp_used` is 1 exactly when `in_class` is conditional jump or call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction description valid |
| in_ready | output | 1 | Block can consume an instruction |
| in_class | input | 3 | 0 other, 1 conditional jump, 2 jump, 3 call, 4 return |
| in_len | input | 3 | Instruction length in bytes (1, 2, 5, 6) |
| in_valc | input | ADDR_W | Embedded constant target |
| ex_mispredict | input | 1 | Execute found a mispredicted conditional jump |
| ex_alt_pc | input | ADDR_W | Correct address for that jump |
| wb_ret_valid | input | 1 | Writeback delivers a return address |
| wb_ret_pc | input | ADDR_W | Return address from writeback |
| fetch_pc | output | ADDR_W | Current fetch address |
| out_valp | output | ADDR_W | Fall-through address of current instruction |
| out_valp_used | output | 1 | Fall-through must travel down the pipe |
| out_pred_taken | output | 1 | Predicted direction for current instruction |

## Verification
A fault in the wait-for-return flag shows at the ports within one cycle. Either `in_ready` stays low after the writeback pulse, or the fetch address moves while it should be frozen. A corrupt fetch address register gives a wrong `out_valp` in the same cycle and a wrong target on the next consumed edge. A broken priority between the two corrections or a wrong direction compare gives a wrong `fetch_pc` one edge after the offending stimulus. The bench therefore compares every cycle against its own model.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    CLS_OTHER = 3'd0,
    CLS_JCOND = 3'd1,
    CLS_JUMP  = 3'd2,
    CLS_CALL  = 3'd3,
    CLS_RET   = 3'd4
  } icls_e;

  localparam int POL_TAKEN     = 0;
  localparam int POL_NOT_TAKEN = 1;
  localparam int POL_BTFNT     = 2;
endpackage

// File: rtl/npc_len_adder.sv
module npc_len_adder #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] valp
);
  always_comb valp = pc + ADDR_W'(len);
endmodule

// File: rtl/npc_predict.sv
module npc_predict import npc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int POLICY = POL_BTFNT
) (
  input  logic [2:0]        cls,
  input  logic [ADDR_W-1:0] valc,
  input  logic [ADDR_W-1:0] valp,
  output logic [ADDR_W-1:0] pred_pc,
  output logic              pred_taken,
  output logic              valp_used,
  output logic              is_ret
);
  logic jcond_taken;

  generate
    if (POLICY == POL_TAKEN) begin : g_taken
      always_comb jcond_taken = 1'b1;
    end else if (POLICY == POL_NOT_TAKEN) begin : g_not_taken
      always_comb jcond_taken = 1'b0;
    end else begin : g_btfnt
      always_comb jcond_taken = (valc < valp);
    end
  endgenerate

  always_comb begin
    pred_taken = 1'b0;
    valp_used  = 1'b0;
    is_ret     = 1'b0;
    case (cls)
      CLS_JCOND: begin pred_taken = jcond_taken; valp_used = 1'b1; end
      CLS_JUMP:  pred_taken = 1'b1;
      CLS_CALL:  begin pred_taken = 1'b1; valp_used = 1'b1; end
      CLS_RET:   is_ret = 1'b1;
      default:   ;
    endcase
    pred_pc = pred_taken ? valc : valp;
  end
endmodule

// File: rtl/npc_select.sv
module npc_select #(
  parameter int ADDR_W = 32
) (
  input  logic              misp,
  input  logic [ADDR_W-1:0] alt_pc,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_pc,
  input  logic              accept,
  input  logic              accept_is_ret,
  input  logic [ADDR_W-1:0] pred_pc,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              cur_wait,
  output logic [ADDR_W-1:0] next_pc,
  output logic              next_wait
);
  always_comb begin
    if (misp) begin
      next_pc   = alt_pc;
      next_wait = 1'b0;
    end else if (ret_valid) begin
      next_pc   = ret_pc;
      next_wait = 1'b0;
    end else if (accept && accept_is_ret) begin
      next_pc   = cur_pc;
      next_wait = 1'b1;
    end else if (accept) begin
      next_pc   = pred_pc;
      next_wait = cur_wait;
    end else begin
      next_pc   = cur_pc;
      next_wait = cur_wait;
    end
  end
endmodule

// File: rtl/npc_predictor.sv
module npc_predictor import npc_pkg::*; #(
  parameter int              ADDR_W   = 32,
  parameter int              POLICY   = POL_BTFNT,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_class,
  input  logic [2:0]        in_len,
  input  logic [ADDR_W-1:0] in_valc,
  input  logic              ex_mispredict,
  input  logic [ADDR_W-1:0] ex_alt_pc,
  input  logic              wb_ret_valid,
  input  logic [ADDR_W-1:0] wb_ret_pc,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] out_valp,
  output logic              out_valp_used,
  output logic              out_pred_taken
);
  logic              ret_wait, next_wait, accept, is_ret;
  logic [ADDR_W-1:0] pred_pc, next_pc;

  assign in_ready = !ret_wait;
  assign accept   = in_valid && in_ready;

  npc_len_adder #(.ADDR_W(ADDR_W), .LEN_W(3)) u_add (
    .pc(fetch_pc), .len(in_len), .valp(out_valp));

  npc_predict #(.ADDR_W(ADDR_W), .POLICY(POLICY)) u_pred (
    .cls(in_class), .valc(in_valc), .valp(out_valp), .pred_pc(pred_pc),
    .pred_taken(out_pred_taken), .valp_used(out_valp_used), .is_ret(is_ret));

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .misp(ex_mispredict), .alt_pc(ex_alt_pc), .ret_valid(wb_ret_valid),
    .ret_pc(wb_ret_pc), .accept(accept), .accept_is_ret(is_ret),
    .pred_pc(pred_pc), .cur_pc(fetch_pc), .cur_wait(ret_wait),
    .next_pc(next_pc), .next_wait(next_wait));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
      ret_wait <= 1'b0;
    end else begin
      fetch_pc <= next_pc;
      ret_wait <= next_wait;
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_len == 3'd1 || in_len == 3'd2 || in_len == 3'd5 || in_len == 3'd6)); // R2
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ex_mispredict && !wb_ret_valid &&
     (in_class == 3'd2 || in_class == 3'd3)) |=> fetch_pc == $past(in_valc)); // R3
  AST_RET_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !ex_mispredict && !wb_ret_valid) |=> ($stable(fetch_pc) && !in_ready)); // R6
  AST_MISP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ex_mispredict |=> (fetch_pc == $past(ex_alt_pc) && in_ready)); // R7
  AST_WB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ret_valid && !ex_mispredict) |=> (fetch_pc == $past(wb_ret_pc) && in_ready)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !ex_mispredict && !wb_ret_valid) |=> $stable(fetch_pc)); // R1
endmodule

// File: tb/npc_predictor_test.sv
`timescale 1ns/1ps
module npc_predictor_test;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready;
  logic [2:0] in_class = 0, in_len = 3'd1;
  logic [AW-1:0] in_valc = '0, ex_alt_pc = '0, wb_ret_pc = '0;
  logic ex_mispredict = 0, wb_ret_valid = 0;
  logic [AW-1:0] fetch_pc, out_valp;
  logic out_valp_used, out_pred_taken;

  int checks = 0, failures = 0;
  logic [AW-1:0] m_pc;
  logic m_wait;

  npc_predictor uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] f_valp(input logic [AW-1:0] pc, input logic [2:0] len);
    return pc + AW'(len);
  endfunction

  function automatic logic f_taken(input logic [2:0] c, input logic [AW-1:0] vc, input logic [AW-1:0] vp);
    if (c == 3'd1) return vc < vp;
    return (c == 3'd2 || c == 3'd3);
  endfunction

  // drive at negedge, check comb outputs, then check state at the next negedge
  task automatic step(input logic v, input logic [2:0] c, input logic [2:0] l,
                      input logic [AW-1:0] vc, input logic mp, input logic [AW-1:0] alt,
                      input logic wr, input logic [AW-1:0] rp);
    logic [AW-1:0] vp, npc;
    logic nw;
    in_valid = v; in_class = c; in_len = l; in_valc = vc;
    ex_mispredict = mp; ex_alt_pc = alt; wb_ret_valid = wr; wb_ret_pc = rp;
    #1;
    vp = f_valp(m_pc, l);
    chk("R2 valp", out_valp, vp);
    chk("R9 valp_used", AW'(out_valp_used), AW'(c == 3'd1 || c == 3'd3));
    chk("R5 pred_taken", AW'(out_pred_taken), AW'(f_taken(c, vc, vp)));
    chk("R6 ready", AW'(in_ready), AW'(!m_wait));
    npc = m_pc; nw = m_wait;
    if (mp) begin npc = alt; nw = 0; end
    else if (wr) begin npc = rp; nw = 0; end
    else if (v && !m_wait) begin
      if (c == 3'd4) nw = 1;
      else npc = f_taken(c, vc, vp) ? vc : vp;
    end
    @(negedge clk);
    m_pc = npc; m_wait = nw;
    chk("R3/R4/R5/R7/R8 fetch_pc", fetch_pc, m_pc);
  endtask

  function automatic logic [2:0] rlen();
    case ($urandom % 4)
      0: return 3'd1;
      1: return 3'd2;
      2: return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  initial begin
    #100000;
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_pc = '0; m_wait = 0;
    chk("R1 reset pc", fetch_pc, '0);
    chk("R1 reset ready", AW'(in_ready), AW'(1));
    step(0, 3'd2, 3'd5, 32'h500, 0, 0, 0, 0);          // R1 idle hold
    step(1, 3'd0, 3'd2, 32'h0, 0, 0, 0, 0);            // R4 other
    step(1, 3'd2, 3'd5, 32'h1000, 0, 0, 0, 0);         // R3 jump
    step(1, 3'd1, 3'd5, 32'h0800, 0, 0, 0, 0);         // R5 backward taken
    step(1, 3'd1, 3'd5, 32'h2000, 0, 0, 0, 0);         // R5 forward not taken
    step(1, 3'd3, 3'd5, 32'h3000, 0, 0, 0, 0);         // R3 call, R9
    step(1, 3'd4, 3'd1, 32'h0, 0, 0, 0, 0);            // R6 return consumed
    step(1, 3'd2, 3'd5, 32'h9999, 0, 0, 0, 0);         // R6 stalled, ignored
    step(1, 3'd0, 3'd1, 32'h0, 0, 0, 1, 32'h0812);     // R6 return arrives
    step(1, 3'd4, 3'd1, 32'h0, 0, 0, 0, 0);            // R6 another return
    step(0, 3'd0, 3'd1, 32'h0, 1, 32'h4444, 1, 32'h5555); // R7 beats R8, clears wait
    step(1, 3'd2, 3'd5, 32'h7777, 0, 0, 1, 32'h6000);  // R8 beats prediction
    step(1, 3'd7, 3'd6, 32'h1, 0, 0, 0, 0);            // R4 unused class code
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c;
      c = 3'($urandom % 6);
      step(($urandom % 4) != 0, (c == 3'd5) ? 3'd1 : c, rlen(), $urandom,
           ($urandom % 16) == 0, $urandom,
           m_wait ? (($urandom % 3) == 0) : (($urandom % 32) == 0), $urandom);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule